// File: doc/BRIEF.md
# Crosspoint Configuration Serial Slave

This block is the configuration front end of a sixteen-port clock crosspoint. It is a slave on a two-wire I2C bus. It keeps one configuration byte per crosspoint port and presents all of them, side by side, to the routing logic on a single wide output. The bus lines are sampled with the system clock through synchronizers. The data line is driven open-drain: the block only ever pulls it low.

Transfers carry no register pointer. After its address byte, a transaction moves a sequential block of bytes that always begins at byte 0 and climbs one byte per transfer. A write stores each byte as it is acknowledged. A read returns the stored bytes in the same order. Two strap inputs set the two low bits of the 7-bit slave address, so that up to four of these blocks can share one bus. An active-low reset clears every byte.

The configuration output is a static register image with no handshake: the router consumes it level-wise, and a byte changes only at the acknowledge of a write. The bus itself throttles transfers, because the slave never stretches the clock.

Top module: `xpt_cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) only an address byte whose top seven bits equal binary 10110 followed by strap_a[1] and then strap_a[0], with bit 0 as read (1) or write (0). Any other address gets no acknowledge, and the bytes that follow it change nothing.
- R2: On a write, data bytes are taken most significant bit first and stored in order to byte 0, 1, 2 and onward. Each one is acknowledged, and the router sees it on cfg_bytes[8k+7:8k] for byte k from the acknowledge bit onward.
- R3: Written bytes 0 to 15 are acknowledged. Any byte written after byte 15 in the same transaction is not acknowledged and leaves every register unchanged.
- R4: On a read, the slave returns the stored bytes most significant bit first, starting at byte 0 and advancing one byte per master acknowledge.
- R5: A read that continues past byte 15 returns 0xFF for every further byte, because SDA is left released.
- R6: A master NACK after a read byte ends the transfer. The slave then keeps SDA released until the next START.
- R7: Every START, including a repeated START inside a transaction, restarts the byte index at 0 for both writes and reads.
- R8: While rst_n is low, all sixteen bytes read 0x00 and SDA is released. They stay 0x00 until they are written.
- R9: After a STOP, the slave ignores bus activity that is not preceded by a START: it gives no acknowledge and writes nothing.
- R10: A change on strap_a takes effect for the next address byte. The old address is then no longer acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset, clears all configuration bytes |
| strap_a | input | 2 | Low two address bits: [1] is address bit 1, [0] is address bit 0 |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_bytes | output | 128 | Configuration image: byte k on bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: sixteen registers, the fixed address prefix 10110 and two synchronizer stages. With sixteen registers, a single 18-byte transaction reaches the index saturation. It shows both the NACK of surplus writes and the 0xFF fill on reads, in one run. The quarter-bit time of eight system clocks leaves several cycles of margin beyond the synchronizer latency, so acknowledge timing is exercised realistically. Address decoding is covered under two strap settings.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int BITCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } xfer_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic scl_d, sda_d, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh[0] <= scl_i;
          sda_sh[0] <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock stays high mark bus conditions
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NREG = 16,
  parameter int IDXW = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDXW-1:0]                widx,
  input  logic [xpt_cfg_pkg::BYTE_W-1:0] wdata,
  input  logic [IDXW-1:0]                rd_idx,
  output logic [xpt_cfg_pkg::BYTE_W-1:0] rd_data,
  output logic [NREG*xpt_cfg_pkg::BYTE_W-1:0] cfg_flat
);
  import xpt_cfg_pkg::*;
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);

  logic [BYTE_W-1:0] mem [NREG];
  logic [SELW-1:0] wsel, rsel;

  assign wsel = widx[SELW-1:0];
  assign rsel = rd_idx[SELW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && (widx < LIMIT)) begin
      mem[wsel] <= wdata;
    end
  end

  assign rd_data = (rd_idx < LIMIT) ? mem[rsel] : '0;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign cfg_flat[g*BYTE_W +: BYTE_W] = mem[g];
    end
  endgenerate
endmodule

// File: rtl/i2c_block_fsm.sv
module i2c_block_fsm #(
  parameter int          NREG    = 16,
  parameter int          IDXW    = 5,
  parameter logic [4:0]  ADDR_HI = 5'b10110
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           scl_rise,
  input  logic                           scl_fall,
  input  logic                           start_p,
  input  logic                           stop_p,
  input  logic                           sda_s,
  input  logic [1:0]                     strap_a,
  input  logic [xpt_cfg_pkg::BYTE_W-1:0] rd_data,
  output logic [IDXW-1:0]                rd_idx,
  output logic                           we,
  output logic [IDXW-1:0]                widx,
  output logic [xpt_cfg_pkg::BYTE_W-1:0] wdata,
  output logic                           sda_oe
);
  import xpt_cfg_pkg::*;
  localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);

  xfer_st_e            st;
  logic [BITCNT_W-1:0] cnt;
  logic [BYTE_W-1:0]   sh, tx;
  logic [IDXW-1:0]     idx, nidx;
  logic                rw, mack;
  logic [BYTE_W-1:0]   load_byte;

  // next index saturates at NREG, which reads as released bus
  assign nidx      = (idx < LIMIT) ? idx + IDXW'(1) : idx;
  assign rd_idx    = (st == ST_RACK) ? nidx : idx;
  assign load_byte = (rd_idx < LIMIT) ? rd_data : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '1;
      idx    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      we     <= 1'b0;
      widx   <= '0;
      wdata  <= '0;
      sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_p) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[BYTE_W-1:1] == {ADDR_HI, strap_a}) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= load_byte;
                sda_oe <= ~load_byte[BYTE_W-1];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (idx < LIMIT) begin
                we     <= 1'b1;
                widx   <= idx;
                wdata  <= sh;
                sda_oe <= 1'b1;
                idx    <= idx + IDXW'(1);
              end
              st <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b1};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                idx    <= nidx;
                tx     <= load_byte;
                sda_oe <= ~load_byte[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xpt_cfg_i2c_slave.sv
module xpt_cfg_i2c_slave #(
  parameter int         NREG        = 16,
  parameter logic [4:0] ADDR_HI     = 5'b10110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             strap_a,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NREG*8-1:0]      cfg_bytes
);
  import xpt_cfg_pkg::*;
  localparam int IDXW = $clog2(NREG + 1);

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic reg_we;
  logic [IDXW-1:0] reg_widx, rd_idx;
  logic [BYTE_W-1:0] reg_wdata, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_block_fsm #(.NREG(NREG), .IDXW(IDXW), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s), .strap_a(strap_a),
    .rd_data(rd_data), .rd_idx(rd_idx), .we(reg_we), .widx(reg_widx),
    .wdata(reg_wdata), .sda_oe(sda_oe)
  );

  cfg_regfile #(.NREG(NREG), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(reg_widx),
    .wdata(reg_wdata), .rd_idx(rd_idx), .rd_data(rd_data),
    .cfg_flat(cfg_bytes)
  );
endmodule

// File: rtl/xpt_cfg_i2c_slave_chk.sv
module xpt_cfg_i2c_slave_chk #(
  parameter int NREG = 16,
  parameter int IDXW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              stop_p,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [IDXW-1:0]   reg_widx,
  input logic [NREG*8-1:0] cfg_bytes
);
  localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (cfg_bytes == '0));

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(cfg_bytes));

  assert_write_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_widx < LIMIT));

  assert_commit_at_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(scl_fall));

  assert_drive_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_release_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_p) |-> !sda_oe);
endmodule

bind xpt_cfg_i2c_slave xpt_cfg_i2c_slave_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .stop_p(stop_p),
  .sda_oe(sda_oe), .reg_we(reg_we), .reg_widx(reg_widx), .cfg_bytes(cfg_bytes)
);

// File: tb/sim_xpt_cfg_i2c_slave.sv
module sim_xpt_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] strap_a;
  logic m_scl, m_sda_low;
  logic sda_oe;
  logic [127:0] cfg_bytes;
  logic sda_line;

  assign sda_line = !(m_sda_low || sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_cfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .scl_i(m_scl),
    .sda_i(sda_line), .sda_oe(sda_oe), .cfg_bytes(cfg_bytes)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] model [16];
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int k = 0; k < 16; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return 8'(seed + k * 29);
  endfunction

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda_low = 1'b0; qwait();
    m_scl = 1'b1;     qwait();
    m_sda_low = 1'b1; qwait();
    m_scl = 1'b0;     qwait();
  endtask

  task automatic i2c_stop();
    m_sda_low = 1'b1; qwait();
    m_scl = 1'b1;     qwait();
    m_sda_low = 1'b0; qwait();
  endtask

  task automatic put_bit(input bit b);
    m_sda_low = !b; qwait();
    m_scl = 1'b1;   qwait(); qwait();
    m_scl = 1'b0;   qwait();
  endtask

  task automatic get_bit(output bit b);
    m_sda_low = 1'b0; qwait();
    m_scl = 1'b1;     qwait();
    b = sda_line;     qwait();
    m_scl = 1'b0;     qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
  endtask

  task automatic wr_block(input logic [6:0] a, input int n, input logic [7:0] seed,
                          output bit aack, output logic [31:0] dack);
    bit b;
    dack = '0;
    i2c_start();
    send_byte({a, 1'b0}, aack);
    if (aack) begin
      for (int k = 0; k < n; k++) begin
        send_byte(pat(seed, k), b);
        dack[k] = b;
      end
    end
    i2c_stop();
  endtask

  // driver: pushes the expected bytes, then captures what the slave returns
  task automatic rd_block(input logic [6:0] a, input int n, input string tag);
    bit aack;
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(k < 16 ? model[k] : 8'hFF);
      tag_q.push_back(k < 16 ? tag : "R5");
    end
    i2c_start();
    send_byte({a, 1'b1}, aack);
    chk(aack, "R4", "read address ack", 128'(aack), 128'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k < n - 1);
      act_q.push_back(d);
    end
    i2c_stop();
  endtask

  // monitor: compares returned bytes against the scoreboard
  initial begin
    logic [7:0] a, e;
    string t;
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, "read byte", 128'(a), 128'(e));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    bit aack, b;
    logic [31:0] dack;
    logic [7:0] d;
    rst_n = 1'b1;
    m_scl = 1'b1;
    m_sda_low = 1'b0;
    strap_a = 2'b10;
    for (int k = 0; k < 16; k++) model[k] = 8'h00;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(cfg_bytes == '0, "R8", "registers in reset", cfg_bytes, '0);
    chk(sda_line == 1'b1, "R8", "sda released in reset", 128'(sda_line), 128'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: wrong address (strap 10 -> 0x5A is ours)
    wr_block(7'h5B, 2, 8'h33, aack, dack);
    chk(!aack, "R1", "foreign address nack", 128'(aack), 128'd0);
    chk(cfg_bytes == model_flat(), "R1", "foreign write ignored", cfg_bytes, model_flat());

    // R1/R2: matching address, three bytes from byte 0
    wr_block(7'h5A, 3, 8'h11, aack, dack);
    for (int k = 0; k < 3; k++) model[k] = pat(8'h11, k);
    chk(aack, "R1", "own address ack", 128'(aack), 128'd1);
    chk(dack[2:0] == 3'b111, "R2", "data acks", 128'(dack), 128'h7);
    chk(cfg_bytes == model_flat(), "R2", "sequential write", cfg_bytes, model_flat());

    // R10: strap change moves the address
    strap_a = 2'b01;
    wr_block(7'h5A, 1, 8'hEE, aack, dack);
    chk(!aack, "R10", "old address nack", 128'(aack), 128'd0);
    wr_block(7'h59, 2, 8'h40, aack, dack);
    for (int k = 0; k < 2; k++) model[k] = pat(8'h40, k);
    chk(aack, "R10", "new address ack", 128'(aack), 128'd1);
    chk(cfg_bytes == model_flat(), "R10", "write via new address", cfg_bytes, model_flat());

    // R3: 18 bytes, last two refused
    wr_block(7'h59, 18, 8'hA5, aack, dack);
    for (int k = 0; k < 16; k++) model[k] = pat(8'hA5, k);
    chk(dack[15:0] == 16'hFFFF, "R3", "acks for bytes 0..15", 128'(dack[15:0]), 128'hFFFF);
    chk(dack[17:16] == 2'b00, "R3", "nack past byte 15", 128'(dack[17:16]), 128'd0);
    chk(cfg_bytes == model_flat(), "R3", "surplus discarded", cfg_bytes, model_flat());

    // R4 / R5: reads
    rd_block(7'h59, 5, "R4");
    rd_block(7'h59, 18, "R4");

    // R6: master nack ends the read, bus stays released
    exp_q.push_back(model[0]); tag_q.push_back("R6");
    exp_q.push_back(model[1]); tag_q.push_back("R6");
    exp_q.push_back(8'hFF);    tag_q.push_back("R6");
    i2c_start();
    send_byte({7'h59, 1'b1}, aack);
    recv_byte(d, 1'b1); act_q.push_back(d);
    recv_byte(d, 1'b0); act_q.push_back(d);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    act_q.push_back(d);
    i2c_stop();

    // R7: repeated start restarts the index for writes
    i2c_start();
    send_byte({7'h59, 1'b0}, aack);
    send_byte(8'h5C, b);
    send_byte(8'h71, b);
    i2c_start();
    send_byte({7'h59, 1'b0}, aack);
    send_byte(8'h9E, b);
    i2c_stop();
    model[0] = 8'h9E;
    model[1] = 8'h71;
    chk(cfg_bytes == model_flat(), "R7", "rewrite from byte 0", cfg_bytes, model_flat());

    // R7: repeated start into a read returns byte 0
    exp_q.push_back(model[0]); tag_q.push_back("R7");
    i2c_start();
    send_byte({7'h59, 1'b0}, aack);
    send_byte(8'hC3, b);
    model[0] = 8'hC3;
    i2c_start();
    send_byte({7'h59, 1'b1}, aack);
    exp_q[exp_q.size()-1] = model[0];
    recv_byte(d, 1'b0); act_q.push_back(d);
    i2c_stop();

    // R9: clocking without a START is ignored
    m_scl = 1'b0; qwait();
    send_byte({7'h59, 1'b0}, aack);
    chk(!aack, "R9", "no ack without start", 128'(aack), 128'd0);
    send_byte(8'h00, b);
    i2c_stop();
    chk(cfg_bytes == model_flat(), "R9", "no write without start", cfg_bytes, model_flat());

    // R8: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg_bytes == '0, "R8", "reset clears registers", cfg_bytes, '0);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) model[k] = 8'h00;
    repeat (4) @(negedge clk);
    rd_block(7'h59, 2, "R8");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "scoreboard drained", 128'(exp_q.size()), 128'd0);
    summary();
    $finish;
  end
endmodule